// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation analog-to-digital converter that serves a 4-bit processor. A one-cycle start strobe launches a conversion. The block then drives a trial code to an external DAC and reads back one comparator bit at a time. It settles the result from the most significant bit down to the least significant. When the last bit is decided, it raises a polled completion flag and emits a one-cycle interrupt request.

A 4-bit control register picks the analog input channel and the operating mode. The 10-bit result is presented in a shape a nibble-wide datapath can consume:

- Bits 9:6 appear on one 4-bit port.
- Bits 5:2 appear on a second 4-bit port.
- Bits 1:0 appear on a third port, left-aligned in the top two bits of the nibble.

The DAC, comparator, analog multiplexer and interrupt controller live outside this block.

Every conversion takes exactly 62 clock cycles from the start strobe to the flag:

- The first 2 cycles are setup time.
- The remaining 60 cycles form ten comparison slots of 6 cycles each.
- The comparator is sampled on the last cycle of each slot, which gives the DAC time to settle.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, the following all read 0: busy, completion flag, interrupt request, all three result nibbles, the channel field and the mode bit.
- R2: A start strobe that is accepted takes effect on the next clock edge. From that edge, busy reads 1 and the trial code reads 0x200, with only bit 9 set.
- R3: Each comparison stores the comparator value (1 when the input is at or above the trial code) into the bit under test, then sets the next lower bit. The final result therefore equals the binary-searched input level, for every level from 0 to 1023.
- R4: The completion flag is still 0 61 cycles after the start edge and reads 1 62 cycles after it. Busy returns to 0 on the same edge that sets the flag.
- R5: The interrupt request is high for exactly one cycle, on the same edge that sets the completion flag.
- R6: A flag-read strobe clears the completion flag on the next edge. An accepted start strobe also clears it. A completion in the same cycle as either strobe leaves the flag set.
- R7: A start strobe during a conversion restarts it from the first trial code. The flag then follows 62 cycles after the new strobe, and the result reflects the input level present after the restart.
- R8: While control bit 3 is 1 (comparator mode), start strobes are ignored: busy and the flag stay 0 and the result does not change.
- R9: A control write stores the 4-bit value. Bits 2:0 drive the channel select output, and bit 3 drives the mode output. The value 0b0001 selects channel 1 in conversion mode.
- R10: The first high nibble port shows result bits 9:6, and the second shows bits 5:2. The low port shows result bits 1:0 in its bits 3:2, with its bits 1:0 reading 0.
- R11: The result ports hold the last completed result throughout any later conversion, until that conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle conversion start strobe |
| ctl_we_i | input | 1 | Control register write enable |
| ctl_wdata_i | input | 4 | Control write data: bit 3 mode, bits 2:0 channel |
| flag_rd_i | input | 1 | Skip-test read of the completion flag; clears it |
| cmp_i | input | 1 | Comparator output: 1 when the input is at or above the DAC level |
| dac_code_o | output | 10 | Trial code driven to the DAC |
| chan_o | output | 3 | Analog channel select |
| cmp_mode_o | output | 1 | 1 = comparator mode, 0 = conversion mode |
| busy_o | output | 1 | Conversion in progress |
| flag_o | output | 1 | Completion flag |
| irq_o | output | 1 | One-cycle interrupt request |
| res_hi_o | output | 4 | Result bits 9:6 |
| res_mid_o | output | 4 | Result bits 5:2 |
| res_lo_o | output | 4 | Result bits 1:0 in bits 3:2; bits 1:0 read 0 |

## Verification
The hardest situation to reach from the ports is a restart partway through a conversion. Reaching it requires the input level to change while the restart happens and the old result to stay visible on the ports. The bench begins a conversion on one random level, then strobes start again 20 cycles later with a different level present. It checks that the result ports keep the previously completed value at the midpoint and that the final result matches the second level. A bench model of the comparator follows the DAC code, so each conversion walks the true binary search. The levels are a seeded random set plus 0, 1023, 511 and 512.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int SAR_BITS = 10;
  localparam int SLOT_CYC = 6;
  localparam int CONV_CYC = 62;

  typedef struct packed {
    logic       cmp_mode;
    logic [2:0] chan;
  } sar_ctl_t;
endpackage

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int N     = 10,
  parameter int SLOT  = 6,
  parameter int TOTAL = 62,
  localparam int IW   = $clog2(N),
  localparam int CW   = $clog2(TOTAL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_go,
  output logic          busy_o,
  output logic          decide_o,
  output logic          done_o,
  output logic [IW-1:0] bit_idx_o
);
  localparam int SETUP = TOTAL - N * SLOT;

  logic          busy_q, busy_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic [IW-1:0] ord_q, ord_nx;
  logic [CW-1:0] target;

  always_comb begin
    target   = CW'(SETUP + SLOT - 1) + CW'(ord_q) * CW'(SLOT);
    decide_o = busy_q && (cnt_q == target);
    done_o   = decide_o && (ord_q == IW'(N - 1));
    busy_o   = busy_q;
    bit_idx_o = IW'(N - 1) - ord_q;
  end

  always_comb begin
    busy_nx = busy_q;
    cnt_nx  = cnt_q;
    ord_nx  = ord_q;
    if (start_go) begin
      busy_nx = 1'b1;
      cnt_nx  = '0;
      ord_nx  = '0;
    end else if (busy_q) begin
      cnt_nx = cnt_q + 1'b1;
      if (done_o) begin
        busy_nx = 1'b0;
        ord_nx  = '0;
      end else if (decide_o) begin
        ord_nx = ord_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      ord_q  <= '0;
    end else begin
      busy_q <= busy_nx;
      cnt_q  <= cnt_nx;
      ord_q  <= ord_nx;
    end
  end

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cnt_q == CW'(TOTAL - 1))); // R4
  AST_SETUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q < CW'(SETUP)) |-> !decide_o); // R4
  AST_ORD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (ord_q < IW'(N))); // R3
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> (busy_q && cnt_q == '0 && ord_q == '0)); // R7
endmodule

// File: rtl/sar_shift.sv
module sar_shift #(
  parameter int N   = 10,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_go,
  input  logic          decide_i,
  input  logic          done_i,
  input  logic [IW-1:0] bit_idx_i,
  input  logic          cmp_i,
  output logic [N-1:0]  code_o,
  output logic [N-1:0]  res_o
);
  localparam logic [N-1:0] FIRST = {1'b1, {(N-1){1'b0}}};

  logic [N-1:0] code_q, code_nx, code_dec;
  logic [N-1:0] res_q, res_nx;

  for (genvar g = 0; g < N; g++) begin : g_bit
    assign code_dec[g] = (bit_idx_i == IW'(g))     ? cmp_i :
                         (bit_idx_i == IW'(g + 1)) ? 1'b1  : code_q[g];
  end

  always_comb begin
    code_nx = code_q;
    res_nx  = res_q;
    if (start_go) begin
      code_nx = FIRST;
    end else if (decide_i) begin
      code_nx = code_dec;
      if (done_i) res_nx = code_dec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      res_q  <= '0;
    end else begin
      code_q <= code_nx;
      res_q  <= res_nx;
    end
  end

  assign code_o = code_q;
  assign res_o  = res_q;

  AST_FIRST_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> (code_q == FIRST)); // R2
  AST_NEXT_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_i && !start_go && bit_idx_i != '0) |=> code_q[$past(bit_idx_i) - 1'b1]); // R3
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |=> $stable(res_q)); // R11
endmodule

// File: rtl/sar_ctl.sv
module sar_ctl
  import sar_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we_i,
  input  logic [3:0] ctl_wdata_i,
  input  logic       start_i,
  input  logic       flag_rd_i,
  input  logic       done_i,
  output logic       start_go_o,
  output sar_ctl_t   ctl_o,
  output logic       flag_o,
  output logic       irq_o
);
  sar_ctl_t ctl_q, ctl_nx;
  logic     flag_q, flag_nx;
  logic     irq_q;

  always_comb begin
    start_go_o = start_i && !ctl_q.cmp_mode;
    ctl_nx     = ctl_we_i ? sar_ctl_t'(ctl_wdata_i) : ctl_q;
    flag_nx    = flag_q;
    if (done_i)                       flag_nx = 1'b1;
    else if (flag_rd_i || start_go_o) flag_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      ctl_q  <= ctl_nx;
      flag_q <= flag_nx;
      irq_q  <= done_i;
    end
  end

  assign ctl_o  = ctl_q;
  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> flag_q); // R6
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd_i && !done_i) |=> !flag_q); // R6
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q); // R5
  AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we_i |=> (ctl_q == sar_ctl_t'($past(ctl_wdata_i)))); // R9
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_pkg::*;
#(
  parameter int N     = SAR_BITS,
  parameter int SLOT  = SLOT_CYC,
  parameter int TOTAL = CONV_CYC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         ctl_we_i,
  input  logic [3:0]   ctl_wdata_i,
  input  logic         flag_rd_i,
  input  logic         cmp_i,
  output logic [N-1:0] dac_code_o,
  output logic [2:0]   chan_o,
  output logic         cmp_mode_o,
  output logic         busy_o,
  output logic         flag_o,
  output logic         irq_o,
  output logic [3:0]   res_hi_o,
  output logic [3:0]   res_mid_o,
  output logic [3:0]   res_lo_o
);
  localparam int IW = $clog2(N);

  logic [1:0]    rst_sync_q;
  logic          rst_sn;
  logic          start_go, decide, done;
  logic [IW-1:0] bit_idx;
  logic [N-1:0]  res;
  sar_ctl_t      ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  sar_ctl i_ctl (
    .clk(clk), .rst_n(rst_sn), .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i),
    .start_i(start_i), .flag_rd_i(flag_rd_i), .done_i(done),
    .start_go_o(start_go), .ctl_o(ctl), .flag_o(flag_o), .irq_o(irq_o)
  );

  sar_seq #(.N(N), .SLOT(SLOT), .TOTAL(TOTAL)) i_seq (
    .clk(clk), .rst_n(rst_sn), .start_go(start_go), .busy_o(busy_o),
    .decide_o(decide), .done_o(done), .bit_idx_o(bit_idx)
  );

  sar_shift #(.N(N)) i_shift (
    .clk(clk), .rst_n(rst_sn), .start_go(start_go), .decide_i(decide),
    .done_i(done), .bit_idx_i(bit_idx), .cmp_i(cmp_i),
    .code_o(dac_code_o), .res_o(res)
  );

  assign chan_o     = ctl.chan;
  assign cmp_mode_o = ctl.cmp_mode;
  assign res_hi_o   = res[N-1 -: 4];
  assign res_mid_o  = res[N-5 -: 4];
  assign res_lo_o   = {res[1:0], 2'b00};

  AST_MODE_BLOCK: assert property (@(posedge clk) disable iff (!rst_sn)
    (start_i && cmp_mode_o && !busy_o) |=> !busy_o); // R8
  AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_sn)
    irq_o |-> (flag_o && !busy_o)); // R5
endmodule

// File: tb/test_sar_adc_ctrl.sv
`timescale 1ns/1ps
module test_sar_adc_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, ctl_we_i = 1'b0, flag_rd_i = 1'b0;
  logic [3:0] ctl_wdata_i = 4'h0;
  logic       cmp_i;
  logic [9:0] dac_code_o;
  logic [2:0] chan_o;
  logic       cmp_mode_o, busy_o, flag_o, irq_o;
  logic [3:0] res_hi_o, res_mid_o, res_lo_o;
  logic [9:0] vin = '0;
  logic [9:0] last_res = '0;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  assign cmp_i = (vin >= dac_code_o);

  sar_adc_ctrl i_sar_adc_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctl_we_i(ctl_we_i),
    .ctl_wdata_i(ctl_wdata_i), .flag_rd_i(flag_rd_i), .cmp_i(cmp_i),
    .dac_code_o(dac_code_o), .chan_o(chan_o), .cmp_mode_o(cmp_mode_o),
    .busy_o(busy_o), .flag_o(flag_o), .irq_o(irq_o),
    .res_hi_o(res_hi_o), .res_mid_o(res_mid_o), .res_lo_o(res_lo_o)
  );

  function automatic logic [11:0] exp_ports(input logic [9:0] v);
    return {v[9:6], v[5:2], v[1:0], 2'b00};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_res(input logic [9:0] v, input string req);
    chk({res_hi_o, res_mid_o, res_lo_o} == exp_ports(v), req,
        {res_hi_o, res_mid_o, res_lo_o}, exp_ports(v));
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic run_conv(input logic [9:0] v, input string req);
    vin = v;
    pulse_start();
    chk(dac_code_o == 10'h200 && busy_o, "R2 first trial", dac_code_o, 10'h200);
    repeat (30) @(negedge clk);
    chk_res(last_res, "R11 result held mid-conversion");
    repeat (31) @(negedge clk);
    chk(!flag_o, "R4 flag early", flag_o, 0);
    @(negedge clk);
    chk(flag_o && !busy_o, "R4 flag at 62", {flag_o, busy_o}, 2'b10);
    chk(irq_o, "R5 irq high", irq_o, 1);
    chk_res(v, req);
    @(negedge clk);
    chk(!irq_o, "R5 irq single cycle", irq_o, 0);
    last_res = v;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({busy_o, flag_o, irq_o, cmp_mode_o} == 4'b0 && chan_o == 3'd0, "R1 reset ctl",
        {busy_o, flag_o, irq_o, cmp_mode_o, chan_o}, 0);
    chk_res(10'd0, "R1 reset result");

    // R9 control write 0001
    @(negedge clk) begin ctl_we_i = 1'b1; ctl_wdata_i = 4'b0001; end
    @(negedge clk) ctl_we_i = 1'b0;
    chk(chan_o == 3'd1 && !cmp_mode_o, "R9 channel 1 conversion", {cmp_mode_o, chan_o}, 4'b0001);

    // R3 R10 directed corners
    run_conv(10'd0,    "R3 R10 level 0");
    run_conv(10'd1023, "R3 R10 level 1023");
    run_conv(10'd512,  "R3 R10 level 512");
    run_conv(10'd511,  "R3 R10 level 511");

    // R6 flag read clears
    chk(flag_o, "R6 flag before read", flag_o, 1);
    @(negedge clk) flag_rd_i = 1'b1;
    @(negedge clk) flag_rd_i = 1'b0;
    chk(!flag_o, "R6 flag cleared by read", flag_o, 0);

    // random levels
    for (int i = 0; i < 20; i++) run_conv(10'($urandom), "R3 R10 random level");

    // R6 start clears flag
    vin = 10'd77;
    pulse_start();
    chk(!flag_o, "R6 start clears flag", flag_o, 0);
    // R7 restart mid-conversion with new level
    repeat (20) @(negedge clk);
    run_conv(10'($urandom), "R7 restart result");

    // R8 comparator mode ignores start
    @(negedge clk) begin ctl_we_i = 1'b1; ctl_wdata_i = 4'b1101; end
    @(negedge clk) ctl_we_i = 1'b0;
    chk(cmp_mode_o && chan_o == 3'd5, "R9 mode and channel", {cmp_mode_o, chan_o}, 4'b1101);
    @(negedge clk) flag_rd_i = 1'b1;
    @(negedge clk) flag_rd_i = 1'b0;
    vin = ~last_res;
    pulse_start();
    chk(!busy_o, "R8 start ignored busy", busy_o, 0);
    repeat (70) @(negedge clk);
    chk(!flag_o && !busy_o, "R8 no completion", {flag_o, busy_o}, 0);
    chk_res(last_res, "R8 result unchanged");

    @(negedge clk) begin ctl_we_i = 1'b1; ctl_wdata_i = 4'b0001; end
    @(negedge clk) ctl_we_i = 1'b0;
    run_conv(10'd341, "R3 R9 conversion after mode return");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule